// File: doc/BRIEF.md
# Bus-Mapped Register-File Arithmetic Unit

This block sits on a 16-bit shared bus as a memory-mapped slave. It holds sixteen 16-bit registers and an arithmetic/logic stage. The upper byte of the bus address selects the unit against a build-time base value. Within the unit, the low nibble names a register and the next nibble names an operation.

A bus write with a matching address stores the bus word into the named register on the rising clock edge. A bus read performs the computation: while the read line is high and the address matches, the unit drives the result of the chosen operation onto the shared data lines. The first operand is the named register and the second is always register 0, which acts as an accumulator. At all other times its drivers float.

No flags are kept, and no carry passes from one operation to the next. Software reaches a result with a single ordinary load from an address that encodes both the operation and the operand.

Top module: `bus_alu_unit`

## Requirements
- R1: Address layout: bits 15..8 must equal the BASE parameter for the unit to respond, bits 7..4 carry the operation code, and bits 3..0 pick the register.
- R2: The sixteen registers are independent: a write to one register leaves the other fifteen unchanged, and no register changes while wr is low.
- R3: When bits 15..8 differ from BASE, a write changes no register and a read leaves data_io undriven.
- R4: On a rising clk edge with wr high and a matching address, the word on data_io is stored into the register picked by bits 3..0.
- R5: The unit drives data_io only while rd is high and the address matches. Otherwise all 16 lines are high-impedance.
- R6: Operand a is the picked register and operand b is register 0. Code 0 returns a unchanged.
- R7: Operation codes: 1 gives a+b, 2 gives b-a, 3 gives a AND b, 4 gives a OR b, 5 gives a XOR b, 6 gives NOT a, 7 gives a shifted left by one with a zero inserted, and 8 gives a shifted right by one with a zero inserted at bit 15.
- R8: Codes 9 through 15 return operand a unchanged.
- R9: An active-low asynchronous reset clears all registers to zero, and addition and subtraction wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address: base, operation code, register index |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read enable; the result is driven while high |
| data_io | inout | 16 | Shared tristate data bus |

## Verification
The bench builds the unit with a BASE of 8'h3C instead of the default 8'hF0. This shows that the decode follows the parameter and not a fixed constant. It also lets the bench place accesses at the default base and at 8'h3D, one bit away, to reach the ignored-write and floating-bus cases. The bench uses the default 16-bit data width with four register bits and four operation bits. Every operation code and every register index are therefore reachable, including the aliasing case where register 0 serves as both operands.

// File: rtl/bus_alu_pkg.sv
package bus_alu_pkg;
  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_RSUB = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_NOT  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8
  } op_e;
endpackage

// File: rtl/bus_alu_decode.sv
module bus_alu_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned OP_W   = 4,
  localparam int unsigned BASE_W = ADDR_W - SEL_W - OP_W,
  parameter logic [BASE_W-1:0] BASE = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEL_W-1:0]  sel,
  output logic [OP_W-1:0]   op
);
  // R1: field split of the bus address
  assign hit = (addr[ADDR_W-1 -: BASE_W] == BASE);
  assign op  = addr[SEL_W +: OP_W];
  assign sel = addr[SEL_W-1:0];
endmodule

// File: rtl/bus_alu_regfile.sv
module bus_alu_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SEL_W-1:0]       wsel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [SEL_W-1:0]       rsel,
  output logic [DATA_W-1:0]      rd_a,
  output logic [DATA_W-1:0]      rd_acc,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (wsel == SEL_W'(g)))
        regs[g] <= wdata;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  assign rd_a   = regs[rsel];
  assign rd_acc = regs[0];
endmodule

// File: rtl/bus_alu_core.sv
module bus_alu_core
  import bus_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 4
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  function automatic logic [DATA_W-1:0] evaluate(
    input logic [3:0]        code,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] acc
  );
    case (code)
      OP_ADD:  return x + acc;
      OP_RSUB: return acc - x;
      OP_AND:  return x & acc;
      OP_OR:   return x | acc;
      OP_XOR:  return x ^ acc;
      OP_NOT:  return ~x;
      OP_SHL:  return {x[DATA_W-2:0], 1'b0};
      OP_SHR:  return {1'b0, x[DATA_W-1:1]};
      default: return x;
    endcase
  endfunction

  assign y = evaluate(4'(op), a, b);
endmodule

// File: rtl/bus_alu_unit.sv
module bus_alu_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned OP_W   = 4,
  localparam int unsigned BASE_W = ADDR_W - SEL_W - OP_W,
  localparam int unsigned NREG   = 1 << SEL_W,
  parameter logic [BASE_W-1:0] BASE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  inout  wire  [DATA_W-1:0] data_io
);
  logic                   unit_hit;
  logic [SEL_W-1:0]       reg_sel;
  logic [OP_W-1:0]        op_code;
  logic                   wr_fire;
  logic                   drive_en;
  logic [DATA_W-1:0]      opnd_a;
  logic [DATA_W-1:0]      opnd_b;
  logic [DATA_W-1:0]      result;
  logic [NREG*DATA_W-1:0] regs_flat;

  bus_alu_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OP_W(OP_W), .BASE(BASE)
  ) u_dec (
    .addr(addr), .hit(unit_hit), .sel(reg_sel), .op(op_code)
  );

  assign wr_fire  = wr & unit_hit;
  assign drive_en = rd & unit_hit;

  bus_alu_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .wsel(reg_sel),
    .wdata(data_io), .rsel(reg_sel), .rd_a(opnd_a), .rd_acc(opnd_b),
    .regs_flat(regs_flat)
  );

  bus_alu_core #(.DATA_W(DATA_W), .OP_W(OP_W)) u_alu (
    .op(op_code), .a(opnd_a), .b(opnd_b), .y(result)
  );

  // R5: tristate driver on the shared bus
  assign data_io = drive_en ? result : {DATA_W{1'bz}};
endmodule

// File: rtl/bus_alu_unit_chk.sv
module bus_alu_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned OP_W   = 4,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr,
  input logic                   rd,
  input logic                   unit_hit,
  input logic                   wr_fire,
  input logic                   drive_en,
  input logic [SEL_W-1:0]       reg_sel,
  input logic [OP_W-1:0]        op_code,
  input logic [DATA_W-1:0]      data_io,
  input logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] rv [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign rv[g] = regs_flat[g*DATA_W +: DATA_W];
  end

  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> rv[$past(reg_sel)] == $past(data_io));

  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !unit_hit) |=> $stable(regs_flat));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(regs_flat));

  p_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> !drive_en);

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && op_code == '0) |-> data_io == rv[reg_sel]);

  p_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && op_code == OP_W'(1)) |-> data_io == DATA_W'(rv[reg_sel] + rv[0]));
endmodule

bind bus_alu_unit bus_alu_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OP_W(OP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .unit_hit(unit_hit),
  .wr_fire(wr_fire), .drive_en(drive_en), .reg_sel(reg_sel),
  .op_code(op_code), .data_io(data_io), .regs_flat(regs_flat)
);

// File: tb/bus_alu_unit_tb.sv
`timescale 1ns/1ps
module bus_alu_unit_tb;
  localparam logic [7:0] TB_BASE = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic        tb_oe = 1'b0;
  logic [15:0] tb_drv = '0;
  wire  [15:0] data_io;

  assign data_io = tb_oe ? tb_drv : 16'hzzzz;

  always #2.5 clk = ~clk;

  bus_alu_unit #(.BASE(TB_BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .data_io(data_io)
  );

  typedef struct {
    logic [15:0] exp;
    bit          float_exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic        chk_valid = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] model [16];

  // Bench restatement of the operations, in integer arithmetic.
  function automatic logic [15:0] ref_op(input int code, input int a, input int b);
    int r;
    case (code)
      1: r = (a + b) % 65536;
      2: r = (b + 65536 - a) % 65536;
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: r = 65535 - a;
      7: r = (a * 2) % 65536;
      8: r = a / 2;
      default: r = a;
    endcase
    return r[15:0];
  endfunction

  task automatic bus_write(input logic [7:0] base, input int sel, input logic [15:0] d);
    @(negedge clk);
    addr = {base, 4'h0, 4'(sel)};
    wr = 1'b1; tb_oe = 1'b1; tb_drv = d;
    @(negedge clk);
    wr = 1'b0; tb_oe = 1'b0;
    if (base == TB_BASE) model[sel] = d;
  endtask

  task automatic bus_read(input logic [7:0] base, input int code, input int sel,
                          input bit do_rd, input string tag);
    item_t it;
    it.float_exp = !(do_rd && base == TB_BASE);
    it.exp = ref_op(code, int'(model[sel]), int'(model[0]));
    it.tag = tag;
    @(negedge clk);
    addr = {base, 4'(code), 4'(sel)};
    rd = do_rd;
    sb_q.push_back(it);
    chk_valid = 1'b1;
    @(negedge clk);
    rd = 1'b0; chk_valid = 1'b0;
  endtask

  // Monitor: sample at the rising edge, inputs change only on falling edges.
  always @(posedge clk) begin
    if (chk_valid && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (it.float_exp) begin
        if (data_io !== 16'hzzzz) begin
          n_fail++;
          $display("FAIL %s: got %h expected zzzz", it.tag, data_io);
        end
      end else if (data_io !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, data_io, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state, R5: idle bus floats
    for (int i = 0; i < 16; i++) bus_read(TB_BASE, 0, i, 1'b1, "R9 reset zero");
    bus_read(TB_BASE, 0, 3, 1'b0, "R5 float rd low");

    // R4 R2: write distinct words, read each back with code 0 (R6)
    for (int i = 0; i < 16; i++) bus_write(TB_BASE, i, 16'h1111 * i + 16'h0F0F);
    for (int i = 0; i < 16; i++) bus_read(TB_BASE, 0, i, 1'b1, "R2 R4 R6 independent regs");

    // R7: all defined operations on two operand patterns
    bus_write(TB_BASE, 0, 16'h00F3);
    bus_write(TB_BASE, 5, 16'hA5C3);
    for (int c = 1; c <= 8; c++) bus_read(TB_BASE, c, 5, 1'b1, "R7 op on r5");
    bus_write(TB_BASE, 9, 16'h8001);
    for (int c = 1; c <= 8; c++) bus_read(TB_BASE, c, 9, 1'b1, "R7 op on r9");
    // Register 0 as both operands
    for (int c = 0; c <= 8; c++) bus_read(TB_BASE, c, 0, 1'b1, "R6 R7 r0 aliasing");

    // R8: unused codes return a
    for (int c = 9; c <= 15; c++) bus_read(TB_BASE, c, 5, 1'b1, "R8 unused code");

    // R9: wrap on add and subtract
    bus_write(TB_BASE, 0, 16'h0002);
    bus_write(TB_BASE, 7, 16'hFFFF);
    bus_read(TB_BASE, 1, 7, 1'b1, "R9 add wrap");
    bus_read(TB_BASE, 2, 7, 1'b1, "R9 sub wrap");

    // R3 R1: mismatched base writes ignored, reads float
    bus_write(8'hF0, 7, 16'h1234);
    bus_write(8'h3D, 7, 16'h5678);
    bus_read(TB_BASE, 0, 7, 1'b1, "R3 write ignored");
    bus_read(8'h3D, 0, 7, 1'b1, "R3 R5 float wrong base");
    bus_read(8'hF0, 1, 7, 1'b1, "R1 default base not decoded");

    // R9: asynchronous reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 16; i++) model[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i += 5) bus_read(TB_BASE, 0, i, 1'b1, "R9 reset clears");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule